// File: doc/BRIEF.md
# Hierarchical Phase-Gated Sequencer

This block is the control unit of a small microcoded coprocessor, split into three nested levels. Level 1 holds an 8-bit task code and steps through the task list. Level 2 splits the current code into a task field and an operand field. A 4-bit counter then walks through the instructions of that task, and two small decode tables turn each step into a micro-operation and a routing value. Level 3 turns each instruction into a one-cycle, one-hot datapath strobe. For an I/O transfer it also waits for an external acknowledge. Each level reports an end-of-execution flag.

A phase generator makes two non-overlapping single-cycle enables, phase A then phase B, from the system clock. A level receives a phase pair only when its own flag and the flags of every deeper level are all high. In free-running mode the phases alternate every cycle. In step mode exactly one pair is issued for each synchronised rising edge of the step input. The level-1 code and the level-2 count are visible on ports for observation.

Phase generator states: `PG_IDLE` (no phase), `PG_P1` (phase A), `PG_P2` (phase B). Its transitions are:
- idle-to-A when free-running or on a step edge;
- A-to-B always;
- B-to-A when free-running or on a fresh step edge;
- B-to-idle in step mode with no edge.

Level-3 states: `L3_READY` and `L3_WAIT`. The transfer-issue transition goes from ready to wait when a transfer strobe is emitted. The acknowledge transition goes from wait back to ready when `xfer_ack` is seen high.

Top module: `hier_sequencer`

## Requirements
- R1: `ph1` and `ph2` are never high together, and every `ph1` cycle is followed by a `ph2` cycle. When free-running they alternate every cycle, starting with `ph1` one cycle after reset is released.
- R2: Level j (1, 2, 3) gets a phase pair only if `eoe` bits j-1 up to 2 were all high in that pair's `ph1` cycle. The `ph2` half is always granted together with its `ph1` half. `l1_code` changes only at the end of a `ph2` cycle.
- R3: `l1_code` advances by 0x11 (8-bit wrap) on each level-1 pair. Its task field is bits [1:0] and its operand field is bits [7:4]. `eoe[0]` is always high.
- R4: `l2_count` clears to 0 on each level-2 pair and otherwise increments on each level-3 pair. `eoe[1]` is high exactly when `l2_count` equals the task field, so task t issues t+1 instructions.
- R5: The instruction issued at count c has micro-op (task + c) mod 5 and route value (operand XOR c). Micro-op codes: 0 add, 1 subtract, 2 increment, 3 decrement, 4 transfer.
- R6: Each level-3 pair raises `strobe` bit (micro-op) alone for exactly one cycle, right after its `ph2` cycle, with `route` updated on the same edge. Otherwise `strobe` is zero.
- R7: After a transfer strobe, `eoe[2]` is low until `xfer_ack` is sampled high. During that time no level advances and no strobe appears.
- R8: With `step_mode` high, the levels advance by exactly one phase pair per rising edge of `step_in`, and by none without an edge.
- R9: During and right after reset, `l1_code` = 0, `l2_count` = 0, `eoe` = 3'b111, `strobe` = 0 and both phases are low. The first level-1 pair therefore executes task 0 and loads code 0x11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_mode | input | 1 | 1 = step-by-step mode, 0 = free-running |
| step_in | input | 1 | Asynchronous step request, synchronised inside |
| xfer_ack | input | 1 | Completion of an I/O transfer |
| ph1 | output | 1 | Global phase A enable |
| ph2 | output | 1 | Global phase B enable |
| eoe | output | 3 | End-of-execution flags, bit 0 = level 1 |
| l1_code | output | 8 | Level-1 state register (observation) |
| l2_count | output | 4 | Level-2 instruction counter |
| strobe | output | 5 | One-hot datapath strobe, bit = micro-op |
| route | output | 4 | Operand routing value of the last strobe |

## Verification
A strobe is due one edge after its `ph2` cycle, so a free-running pair shows its strobe within two cycles. A step edge needs three edges of synchronisation and phase start before the pair begins. The bench therefore does not count exact cycles. A monitor samples `strobe` and `route` on every falling edge and records each non-zero strobe in order. Each scenario waits with a generous margin before comparing the recorded list with one computed from R3 to R5, and it checks stalls by confirming that no extra event arrives in the margin.

// File: rtl/hseq_pkg.sv
package hseq_pkg;
    localparam int NUM_LEVELS = 3;
    localparam int NUM_UOPS   = 5;

    typedef enum logic [1:0] {PG_IDLE, PG_P1, PG_P2} pg_state_t;
    typedef enum logic [2:0] {
        UOP_ADD  = 3'd0,
        UOP_SUB  = 3'd1,
        UOP_INC  = 3'd2,
        UOP_DEC  = 3'd3,
        UOP_XFER = 3'd4
    } uop_t;
    typedef enum logic {L3_READY, L3_WAIT} l3_state_t;
endpackage

// File: rtl/hseq_phase_gen.sv
module hseq_phase_gen
    import hseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_mode,
    input  logic step_in,
    output logic ph1,
    output logic ph2
);
    localparam int SYNC_W = SYNC_STAGES + 1;

    logic [SYNC_W-1:0] sync_q;
    logic              step_edge;
    pg_state_t         state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_W-2:0], step_in};
    end
    assign step_edge = sync_q[SYNC_W-2] & ~sync_q[SYNC_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PG_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PG_IDLE: if (!step_mode || step_edge) state_nx = PG_P1;
            PG_P1:   state_nx = PG_P2;
            PG_P2:   state_nx = (!step_mode || step_edge) ? PG_P1 : PG_IDLE;
            default: state_nx = PG_IDLE;
        endcase
    end

    always_comb begin
        ph1 = (state == PG_P1);
        ph2 = (state == PG_P2);
    end

    a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph1 && ph2));
    a_r1_b_follows_a: assert property (@(posedge clk) disable iff (!rst_n)
        ph1 |=> ph2);
endmodule

// File: rtl/hseq_level1.sv
module hseq_level1 #(
    parameter int              CODE_W   = 8,
    parameter logic [CODE_W-1:0] STEP_INC = 8'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph1_en,
    input  logic              ph2_en,
    output logic [CODE_W-1:0] code,
    output logic              ee
);
    logic [CODE_W-1:0] master_q, slave_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= '0;
            slave_q  <= '0;
        end else begin
            if (ph1_en) master_q <= slave_q + STEP_INC;
            if (ph2_en) slave_q  <= master_q;
        end
    end

    assign code = slave_q;
    // every level-1 task completes within its single phase pair
    assign ee   = 1'b1;

    a_r3_code_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slave_q) |-> (slave_q == $past(slave_q) + STEP_INC));
endmodule

// File: rtl/hseq_level2.sv
module hseq_level2
    import hseq_pkg::*;
#(
    parameter int TASK_W  = 2,
    parameter int CNT_W   = 4,
    parameter int ROUTE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TASK_W-1:0]  task_f,
    input  logic [ROUTE_W-1:0] oper_f,
    input  logic               load_ph1,
    input  logic               step_ph1,
    input  logic               ph2_en,
    output logic [CNT_W-1:0]   count,
    output logic               ee,
    output uop_t               uop,
    output logic [ROUTE_W-1:0] route
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] master_q, slave_q;
    logic [SUM_W-1:0] sum;
    logic [2:0]       sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= '0;
            slave_q  <= '0;
        end else begin
            if (load_ph1)            master_q <= '0;
            else if (step_ph1 && !ee) master_q <= slave_q + 1'b1;
            if (ph2_en)              slave_q  <= master_q;
        end
    end

    assign count = slave_q;
    assign ee    = (slave_q == CNT_W'(task_f));

    // task-code machine: micro-op table
    always_comb begin
        sum = SUM_W'(task_f) + SUM_W'(slave_q);
        sel = 3'(sum % 5);
        unique case (sel)
            3'd0:    uop = UOP_ADD;
            3'd1:    uop = UOP_SUB;
            3'd2:    uop = UOP_INC;
            3'd3:    uop = UOP_DEC;
            3'd4:    uop = UOP_XFER;
            default: uop = UOP_ADD;
        endcase
    end

    // operand machine: routing value
    assign route = oper_f ^ ROUTE_W'(slave_q);

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        slave_q <= CNT_W'(task_f));
endmodule

// File: rtl/hseq_level3.sv
module hseq_level3
    import hseq_pkg::*;
#(
    parameter int ROUTE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ph1_en,
    input  logic                ph2_en,
    input  uop_t                uop_in,
    input  logic [ROUTE_W-1:0]  route_in,
    input  logic                xfer_ack,
    output logic [NUM_UOPS-1:0] strobe,
    output logic [ROUTE_W-1:0]  route,
    output logic                ee
);
    uop_t               m_uop;
    logic [ROUTE_W-1:0] m_route;
    l3_state_t          state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= L3_READY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            L3_READY: if (ph2_en && m_uop == UOP_XFER) state_nx = L3_WAIT;
            L3_WAIT:  if (xfer_ack) state_nx = L3_READY;
            default:  state_nx = L3_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_uop   <= UOP_ADD;
            m_route <= '0;
            route   <= '0;
            strobe  <= '0;
        end else begin
            if (ph1_en) begin
                m_uop   <= uop_in;
                m_route <= route_in;
            end
            if (ph2_en) begin
                strobe <= NUM_UOPS'(1) << m_uop;
                route  <= m_route;
            end else begin
                strobe <= '0;
            end
        end
    end

    assign ee = (state == L3_READY);

    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe));
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe != '0) |=> (strobe == '0));
    a_r7_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state == L3_WAIT && $past(state == L3_WAIT)) |-> (strobe == '0));
endmodule

// File: rtl/hier_sequencer.sv
module hier_sequencer
    import hseq_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int TASK_W  = 2,
    parameter int CNT_W   = 4,
    parameter int ROUTE_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step_mode,
    input  logic                  step_in,
    input  logic                  xfer_ack,
    output logic                  ph1,
    output logic                  ph2,
    output logic [NUM_LEVELS-1:0] eoe,
    output logic [CODE_W-1:0]     l1_code,
    output logic [CNT_W-1:0]      l2_count,
    output logic [NUM_UOPS-1:0]   strobe,
    output logic [ROUTE_W-1:0]    route
);
    localparam logic [CODE_W-1:0] STEP_INC = CODE_W'(8'h11);

    logic [NUM_LEVELS-1:0] eoe_i, gate, hold, ph1_l, ph2_l;
    uop_t                  l2_uop;
    logic [ROUTE_W-1:0]    l2_route;

    hseq_phase_gen #(.SYNC_STAGES(2)) u_phase (
        .clk(clk), .rst_n(rst_n), .step_mode(step_mode), .step_in(step_in),
        .ph1(ph1), .ph2(ph2)
    );

    // level j is enabled when its own flag and every deeper flag are high
    for (genvar j = 0; j < NUM_LEVELS; j++) begin : g_gate
        localparam logic [NUM_LEVELS-1:0] SHALLOW = NUM_LEVELS'((1 << j) - 1);
        assign gate[j] = &(eoe_i | SHALLOW);
        always_ff @(posedge clk) begin
            if (!rst_n)   hold[j] <= 1'b0;
            else if (ph1) hold[j] <= gate[j];
        end
        assign ph1_l[j] = ph1 & gate[j];
        assign ph2_l[j] = ph2 & hold[j];
    end

    hseq_level1 #(.CODE_W(CODE_W), .STEP_INC(STEP_INC)) u_lvl1 (
        .clk(clk), .rst_n(rst_n), .ph1_en(ph1_l[0]), .ph2_en(ph2_l[0]),
        .code(l1_code), .ee(eoe_i[0])
    );

    hseq_level2 #(.TASK_W(TASK_W), .CNT_W(CNT_W), .ROUTE_W(ROUTE_W)) u_lvl2 (
        .clk(clk), .rst_n(rst_n),
        .task_f(l1_code[TASK_W-1:0]), .oper_f(l1_code[CODE_W-1 -: ROUTE_W]),
        .load_ph1(ph1_l[1]), .step_ph1(ph1_l[2]), .ph2_en(ph2_l[2]),
        .count(l2_count), .ee(eoe_i[1]), .uop(l2_uop), .route(l2_route)
    );

    hseq_level3 #(.ROUTE_W(ROUTE_W)) u_lvl3 (
        .clk(clk), .rst_n(rst_n), .ph1_en(ph1_l[2]), .ph2_en(ph2_l[2]),
        .uop_in(l2_uop), .route_in(l2_route), .xfer_ack(xfer_ack),
        .strobe(strobe), .route(route), .ee(eoe_i[2])
    );

    assign eoe = eoe_i;

    a_r2_code_on_b: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(l1_code) |-> $past(ph2_l[0]));
    a_r2_pair_whole: assert property (@(posedge clk) disable iff (!rst_n)
        ph2_l[0] |-> $past(ph1_l[0]));
    a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !eoe_i[2] |=> $stable(l1_code));
endmodule

// File: tb/test_hier_sequencer.sv
module test_hier_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_EV     = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_mode = 1'b0;
    logic       step_in = 1'b0;
    logic       xfer_ack = 1'b0;
    logic       ph1, ph2;
    logic [2:0] eoe;
    logic [7:0] l1_code;
    logic [3:0] l2_count;
    logic [4:0] strobe;
    logic [3:0] route;

    int n_tests = 0;
    int n_fail  = 0;
    int n_ev    = 0;
    logic [4:0] ev_s [MAX_EV];
    logic [3:0] ev_r [MAX_EV];
    logic [4:0] exp_s [MAX_EV];
    logic [3:0] exp_r [MAX_EV];

    always #(CLK_PERIOD/2) clk = ~clk;

    hier_sequencer i_hier_sequencer (
        .clk(clk), .rst_n(rst_n), .step_mode(step_mode), .step_in(step_in),
        .xfer_ack(xfer_ack), .ph1(ph1), .ph2(ph2), .eoe(eoe),
        .l1_code(l1_code), .l2_count(l2_count), .strobe(strobe), .route(route)
    );

    // strobe event recorder
    always @(negedge clk) begin
        if (!rst_n) n_ev = 0;
        else if (strobe != 5'd0 && n_ev < MAX_EV) begin
            ev_s[n_ev] = strobe;
            ev_r[n_ev] = route;
            n_ev++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic build_expected();
        logic [7:0] code = 8'h00;
        int idx = 0;
        while (idx < MAX_EV) begin
            int tsk = int'(code[1:0]);
            for (int c = 0; c <= tsk && idx < MAX_EV; c++) begin
                exp_s[idx] = 5'(1 << ((tsk + c) % 5));
                exp_r[idx] = code[7:4] ^ 4'(c);
                idx++;
            end
            code = code + 8'h11;
        end
    endtask

    task automatic check_events(input int first, input int last, input string req);
        for (int k = first; k <= last; k++) begin
            check(ev_s[k] == exp_s[k], {req, " strobe"}, int'(ev_s[k]), int'(exp_s[k]));
            check(ev_r[k] == exp_r[k], {req, " route"},  int'(ev_r[k]), int'(exp_r[k]));
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0; step_mode = mode; step_in = 1'b0; xfer_ack = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk) xfer_ack = 1'b1;
        @(negedge clk) xfer_ack = 1'b0;
    endtask

    task automatic pulse_step();
        @(negedge clk) step_in = 1'b1;
        repeat (4) @(negedge clk);
        step_in = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    // R9: state held in reset
    task automatic t_reset();
        do_reset(1'b0);
        check(l1_code == 8'h00, "R9 code", l1_code, 0);
        check(l2_count == 4'd0, "R9 count", l2_count, 0);
        check(eoe == 3'b111, "R9 eoe", eoe, 7);
        check(strobe == 5'd0, "R9 strobe", strobe, 0);
        check(!ph1 && !ph2, "R9 phases", {ph1, ph2}, 0);
    endtask

    // R1..R7: free-running run through three transfer stalls
    task automatic t_free_run();
        logic p_prev;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check(ph1 && !ph2, "R1 first phase", {ph1, ph2}, 2);
        p_prev = ph1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check((ph1 != ph2) && (ph1 != p_prev), "R1 alternate", {ph1, ph2}, {!p_prev, p_prev});
            p_prev = ph1;
        end
        for (int k = 0; k < 200 && n_ev < 6; k++) @(negedge clk);
        repeat (10) @(negedge clk);
        check(n_ev == 6, "R7 stall count", n_ev, 6);
        check_events(0, 5, "R5 R6 first tasks");
        check(l1_code == 8'h33, "R3 code", l1_code, 8'h33);
        check(l2_count == 4'd0, "R4 cleared", l2_count, 0);
        check(eoe == 3'b001, "R7 eoe", eoe, 1);
        pulse_ack();
        repeat (30) @(negedge clk);
        check(n_ev == 8, "R7 second stall", n_ev, 8);
        check_events(6, 7, "R5 task3 start");
        check(l2_count == 4'd2, "R4 mid count", l2_count, 2);
        check(eoe[1] == 1'b0, "R4 ee2 low mid-task", eoe[1], 0);
        check(l1_code == 8'h33, "R2 code held", l1_code, 8'h33);
        pulse_ack();
        repeat (40) @(negedge clk);
        check(n_ev == 16, "R7 third stall", n_ev, 16);
        check_events(8, 15, "R5 R6 later tasks");
        check(l1_code == 8'h77, "R3 code later", l1_code, 8'h77);
        check(l2_count == 4'd0, "R4 reload", l2_count, 0);
    endtask

    // R8: step-by-step mode
    task automatic t_step();
        do_reset(1'b1);
        @(negedge clk) rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(n_ev == 0, "R8 no edge no step", n_ev, 0);
        check(l1_code == 8'h00, "R8 code idle", l1_code, 0);
        pulse_step();
        check(n_ev == 1, "R8 one pair", n_ev, 1);
        check_events(0, 0, "R8 first instr");
        check(l1_code == 8'h11, "R8 code step1", l1_code, 8'h11);
        check(l2_count == 4'd0, "R8 count step1", l2_count, 0);
        pulse_step();
        check(n_ev == 2, "R8 second pair", n_ev, 2);
        check_events(1, 1, "R8 second instr");
        check(l2_count == 4'd1, "R8 count step2", l2_count, 1);
        check(eoe == 3'b111, "R4 ee2 at terminal", eoe, 7);
    endtask

    initial begin
        build_expected();
        t_reset();
        t_free_run();
        t_step();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule